// File: doc/BRIEF.md
# Absolute-time pulse scheduler

This block is one channel of a timing generator. It emits a single pulse whose leading and trailing edges are placed at absolute times on a shared time base. The time base is given as a seconds count and a count of reference cycles within the second, which wraps at a fixed number of cycles per second: 125,000,000 at 125 MHz. Each edge time has three parts: seconds, a cycle count, and a 12-bit fraction of one 8 ns cycle. In that fraction, 0 stands for 0 ps and 4095 stands for just under 8 ns. The block uses the whole-cycle parts itself. It passes the fractions through to an external delay line, which adds the sub-cycle part of each edge.

The host writes the six time fields into shadow registers through a small write port. It then pulses an update command. The block copies all six fields into its active registers in one step. A done flag is low while this copy is in flight and goes high again once the copy has completed.

After the update, the host arms the scheduler. The arm is accepted only if the start time lies at least a minimum lead ahead of the current time: 25 cycles, or 200 ns. An accepted arm waits for the start time, drives the pulse, and releases it at the end time. It then sets a triggered flag. A polarity input chooses whether the active level of the pulse is high or low.

Top module: `abs_pulse_sched`

## Requirements
- R1: After reset, done_o is 1, trig_o and err_o are 0, both strobes are 0, both fine outputs are 0, and pulse_o is at its inactive level.
- R2: A write with wr_i high stores the low bits of wr_data_i into one shadow field, truncated to that field's width. The field is selected by wr_addr_i: 0 start seconds, 1 start cycles, 2 start fraction, 3 end seconds, 4 end cycles, 5 end fraction. Codes 6 and 7 change nothing.
- R3: An update_i pulse accepted while done_o is 1 drives done_o low for exactly UPD_LAT cycles, starting the cycle after the pulse. All six active fields change together at the edge where done_o returns to 1. start_fine_o and end_fine_o show the active fractions.
- R4: The copy uses the shadow contents as they were when update_i was accepted. Shadow writes made during the copy do not reach the active fields until a later update. An update_i while done_o is 0 is ignored.
- R5: An arm_i pulse is accepted only if the active start time is at least MIN_LEAD cycles after the time base value at that edge. The comparison includes the carry of the cycle count into seconds at CYC_PER_SEC.
- R6: A rejected arm sets err_o to 1 and leaves the block idle, with no pulse. An accepted arm clears err_o.
- R7: After an accepted arm, pulse_o goes active on the edge where the time base equals the start seconds and cycles. It is therefore visible one cycle later. pulse_o returns to inactive on the edge where the time base equals the end time. The end time must be later than the start time.
- R8: start_stb_o and end_stb_o are single-cycle strobes. Each is high in the cycle in which pulse_o has just gone active or inactive, respectively.
- R9: trig_o rises together with end_stb_o and stays 1 until the next arm_i, which clears it. After the end time the block stays idle, so it fires once per arm.
- R10: pulse_o drives pol_i as its active level and the inverse of pol_i as its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tb_sec_i | input | SEC_W | Time base, seconds |
| tb_cyc_i | input | CYC_W | Time base, cycles within the second |
| wr_i | input | 1 | Shadow field write strobe |
| wr_addr_i | input | 3 | Shadow field select |
| wr_data_i | input | DATA_W | Shadow write data |
| update_i | input | 1 | Request atomic copy of the shadow fields to the active fields |
| arm_i | input | 1 | Arm the scheduler |
| pol_i | input | 1 | Active level of pulse_o |
| pulse_o | output | 1 | Scheduled pulse |
| start_stb_o | output | 1 | One-cycle strobe at the coarse leading edge |
| end_stb_o | output | 1 | One-cycle strobe at the coarse trailing edge |
| start_fine_o | output | FINE_W | Active start fraction for the delay line |
| end_fine_o | output | FINE_W | Active end fraction for the delay line |
| done_o | output | 1 | Update copy complete |
| trig_o | output | 1 | Pulse has been produced |
| err_o | output | 1 | Last arm violated the minimum lead |

## Verification
The hardest case to reach is an arm whose margin lies right at the minimum lead while the start time also crosses a seconds boundary. A rejected arm at that point, or an edge comparison that misses the carry, shows up only there. The bench runs with only 50 cycles per second. It sweeps the lead from 0 to 40 cycles against an arm moment that drifts through the second, so both the boundary at 25 cycles and the cycle wraparound are hit many times. A second situation is a shadow write and a second update that arrive while a copy is still in flight. The bench issues both in the first busy cycle and shows their effect only through the fraction outputs after later updates.

// File: rtl/sched_pkg.sv
package sched_pkg;

   // Shadow field select codes; the end fields sit three codes after the start fields.
   typedef enum logic [2:0] {
      FLD_START_SEC  = 3'd0,
      FLD_START_CYC  = 3'd1,
      FLD_START_FINE = 3'd2,
      FLD_END_SEC    = 3'd3,
      FLD_END_CYC    = 3'd4,
      FLD_END_FINE   = 3'd5
   } fld_e;

   typedef enum logic [1:0] {
      RUN_IDLE   = 2'd0,
      RUN_WAIT   = 2'd1,
      RUN_ACTIVE = 2'd2
   } run_e;

   localparam int NUM_EDGES = 2;

   function automatic logic [2:0] fld_code(input int edge_idx, input int part);
      return 3'(edge_idx * 3 + part);
   endfunction

endpackage

// File: rtl/sched_shadow.sv
module sched_shadow
   import sched_pkg::*;
#(
   parameter int SEC_W   = 32,
   parameter int CYC_W   = 28,
   parameter int FINE_W  = 12,
   parameter int DATA_W  = 32,
   parameter int UPD_LAT = 3
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic                                 wr_i,
   input  logic [2:0]                           wr_addr_i,
   input  logic [DATA_W-1:0]                    wr_data_i,
   input  logic                                 update_i,
   output logic [NUM_EDGES-1:0][SEC_W-1:0]      act_sec_o,
   output logic [NUM_EDGES-1:0][CYC_W-1:0]      act_cyc_o,
   output logic [NUM_EDGES-1:0][FINE_W-1:0]     act_fine_o,
   output logic                                 done_o
);

   localparam int CNT_W = $clog2(UPD_LAT + 1);

   if (UPD_LAT < 1) begin : g_bad_lat
      $error("sched_shadow: UPD_LAT must be at least 1");
   end
   if (SEC_W > DATA_W || CYC_W > DATA_W || FINE_W > DATA_W) begin : g_bad_width
      $error("sched_shadow: a time field is wider than the write data");
   end

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             take;
   logic             commit;

   assign take   = update_i && !busy_q;
   assign commit = busy_q && (cnt_q == CNT_W'(1));
   assign done_o = !busy_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(UPD_LAT);
      end else if (busy_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (commit) busy_q <= 1'b0;
      end
   end

   for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
      localparam logic [2:0] A_SEC  = fld_code(e, 0);
      localparam logic [2:0] A_CYC  = fld_code(e, 1);
      localparam logic [2:0] A_FINE = fld_code(e, 2);

      logic [SEC_W-1:0]  sh_sec,  stg_sec,  act_sec;
      logic [CYC_W-1:0]  sh_cyc,  stg_cyc,  act_cyc;
      logic [FINE_W-1:0] sh_fine, stg_fine, act_fine;

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            sh_sec   <= '0;
            sh_cyc   <= '0;
            sh_fine  <= '0;
            stg_sec  <= '0;
            stg_cyc  <= '0;
            stg_fine <= '0;
            act_sec  <= '0;
            act_cyc  <= '0;
            act_fine <= '0;
         end else begin
            if (wr_i && wr_addr_i == A_SEC)  sh_sec  <= wr_data_i[SEC_W-1:0];
            if (wr_i && wr_addr_i == A_CYC)  sh_cyc  <= wr_data_i[CYC_W-1:0];
            if (wr_i && wr_addr_i == A_FINE) sh_fine <= wr_data_i[FINE_W-1:0];
            if (take) begin
               stg_sec  <= sh_sec;
               stg_cyc  <= sh_cyc;
               stg_fine <= sh_fine;
            end
            if (commit) begin
               act_sec  <= stg_sec;
               act_cyc  <= stg_cyc;
               act_fine <= stg_fine;
            end
         end
      end

      assign act_sec_o[e]  = act_sec;
      assign act_cyc_o[e]  = act_cyc;
      assign act_fine_o[e] = act_fine;
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data_i;

   AST_DONE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      update_i && done_o |=> !done_o); // R3

   AST_ACT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o && $past(!done_o) |-> $stable(act_sec_o) && $stable(act_cyc_o) && $stable(act_fine_o)); // R4

   AST_BUSY_UPD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o && update_i && cnt_q != CNT_W'(1) |=> !done_o); // R4

endmodule

// File: rtl/sched_lead_check.sv
module sched_lead_check #(
   parameter int SEC_W       = 32,
   parameter int CYC_W       = 28,
   parameter int CYC_PER_SEC = 125000000,
   parameter int MIN_LEAD    = 25
) (
   input  logic [SEC_W-1:0] tb_sec_i,
   input  logic [CYC_W-1:0] tb_cyc_i,
   input  logic [SEC_W-1:0] start_sec_i,
   input  logic [CYC_W-1:0] start_cyc_i,
   output logic             ok_o
);

   localparam logic [CYC_W:0] LEAD_EXT = (CYC_W + 1)'(MIN_LEAD);
   localparam logic [CYC_W:0] WRAP_EXT = (CYC_W + 1)'(CYC_PER_SEC);

   if (MIN_LEAD < 0 || MIN_LEAD >= CYC_PER_SEC) begin : g_bad_lead
      $error("sched_lead_check: MIN_LEAD must lie below CYC_PER_SEC");
   end

   logic [CYC_W:0]   sum;
   logic [CYC_W:0]   sum_wrapped;
   logic             carry;
   logic [CYC_W-1:0] thr_cyc;
   logic [SEC_W-1:0] thr_sec;

   always_comb begin
      sum         = {1'b0, tb_cyc_i} + LEAD_EXT;
      carry       = (sum >= WRAP_EXT);
      sum_wrapped = sum - WRAP_EXT;
      thr_cyc     = carry ? sum_wrapped[CYC_W-1:0] : sum[CYC_W-1:0];
      thr_sec     = tb_sec_i + SEC_W'(carry);
      ok_o        = (start_sec_i > thr_sec) ||
                    ((start_sec_i == thr_sec) && (start_cyc_i >= thr_cyc));
   end

endmodule

// File: rtl/sched_fire.sv
module sched_fire
   import sched_pkg::*;
#(
   parameter int SEC_W = 32,
   parameter int CYC_W = 28
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic [SEC_W-1:0]                tb_sec_i,
   input  logic [CYC_W-1:0]                tb_cyc_i,
   input  logic [NUM_EDGES-1:0][SEC_W-1:0] edge_sec_i,
   input  logic [NUM_EDGES-1:0][CYC_W-1:0] edge_cyc_i,
   input  logic                            arm_i,
   input  logic                            lead_ok_i,
   output logic                            active_o,
   output logic                            start_stb_o,
   output logic                            end_stb_o,
   output logic                            trig_o,
   output logic                            err_o
);

   logic [NUM_EDGES-1:0] hit;

   for (genvar e = 0; e < NUM_EDGES; e++) begin : g_cmp
      assign hit[e] = (tb_sec_i == edge_sec_i[e]) && (tb_cyc_i == edge_cyc_i[e]);
   end

   run_e state_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q     <= RUN_IDLE;
         start_stb_o <= 1'b0;
         end_stb_o   <= 1'b0;
         trig_o      <= 1'b0;
         err_o       <= 1'b0;
      end else begin
         start_stb_o <= 1'b0;
         end_stb_o   <= 1'b0;
         if (arm_i) begin
            trig_o <= 1'b0;
            if (lead_ok_i) begin
               state_q <= RUN_WAIT;
               err_o   <= 1'b0;
            end else begin
               state_q <= RUN_IDLE;
               err_o   <= 1'b1;
            end
         end else begin
            case (state_q)
               RUN_WAIT: begin
                  if (hit[0]) begin
                     state_q     <= RUN_ACTIVE;
                     start_stb_o <= 1'b1;
                  end
               end
               RUN_ACTIVE: begin
                  if (hit[1]) begin
                     state_q   <= RUN_IDLE;
                     end_stb_o <= 1'b1;
                     trig_o    <= 1'b1;
                  end
               end
               default: state_q <= RUN_IDLE;
            endcase
         end
      end
   end

   assign active_o = (state_q == RUN_ACTIVE);

   AST_BAD_ARM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i && !lead_ok_i |=> err_o && !active_o); // R6

   AST_START_STB_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_stb_o |-> active_o); // R8

   AST_START_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_stb_o |=> !start_stb_o); // R8

   AST_END_STB_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_stb_o |-> !active_o && trig_o); // R9

   AST_TRIG_CLEARED_BY_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i |=> !trig_o); // R9

endmodule

// File: rtl/abs_pulse_sched.sv
module abs_pulse_sched
   import sched_pkg::*;
#(
   parameter int SEC_W       = 32,
   parameter int CYC_W       = 28,
   parameter int FINE_W      = 12,
   parameter int DATA_W      = 32,
   parameter int CYC_PER_SEC = 125000000,
   parameter int MIN_LEAD    = 25,
   parameter int UPD_LAT     = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SEC_W-1:0]  tb_sec_i,
   input  logic [CYC_W-1:0]  tb_cyc_i,
   input  logic              wr_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              update_i,
   input  logic              arm_i,
   input  logic              pol_i,
   output logic              pulse_o,
   output logic              start_stb_o,
   output logic              end_stb_o,
   output logic [FINE_W-1:0] start_fine_o,
   output logic [FINE_W-1:0] end_fine_o,
   output logic              done_o,
   output logic              trig_o,
   output logic              err_o
);

   if (CYC_PER_SEC < 1 || longint'(CYC_PER_SEC) > (64'd1 << CYC_W)) begin : g_bad_rate
      $error("abs_pulse_sched: CYC_PER_SEC does not fit the cycle field");
   end

   logic [NUM_EDGES-1:0][SEC_W-1:0]  act_sec;
   logic [NUM_EDGES-1:0][CYC_W-1:0]  act_cyc;
   logic [NUM_EDGES-1:0][FINE_W-1:0] act_fine;
   logic                             lead_ok;
   logic                             active;

   sched_shadow #(
      .SEC_W(SEC_W), .CYC_W(CYC_W), .FINE_W(FINE_W), .DATA_W(DATA_W), .UPD_LAT(UPD_LAT)
   ) i_shadow (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_i(wr_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .update_i(update_i),
      .act_sec_o(act_sec), .act_cyc_o(act_cyc), .act_fine_o(act_fine),
      .done_o(done_o)
   );

   sched_lead_check #(
      .SEC_W(SEC_W), .CYC_W(CYC_W), .CYC_PER_SEC(CYC_PER_SEC), .MIN_LEAD(MIN_LEAD)
   ) i_lead (
      .tb_sec_i(tb_sec_i), .tb_cyc_i(tb_cyc_i),
      .start_sec_i(act_sec[0]), .start_cyc_i(act_cyc[0]),
      .ok_o(lead_ok)
   );

   sched_fire #(
      .SEC_W(SEC_W), .CYC_W(CYC_W)
   ) i_fire (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .tb_sec_i(tb_sec_i), .tb_cyc_i(tb_cyc_i),
      .edge_sec_i(act_sec), .edge_cyc_i(act_cyc),
      .arm_i(arm_i), .lead_ok_i(lead_ok),
      .active_o(active), .start_stb_o(start_stb_o), .end_stb_o(end_stb_o),
      .trig_o(trig_o), .err_o(err_o)
   );

   assign pulse_o      = active ? pol_i : !pol_i;
   assign start_fine_o = act_fine[0];
   assign end_fine_o   = act_fine[1];

   AST_TRIG_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |-> pulse_o == !pol_i); // R9

   AST_ERR_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> pulse_o == !pol_i); // R6

endmodule

// File: tb/test_abs_pulse_sched.sv
`timescale 1ns/1ps
module test_abs_pulse_sched;

   localparam int CPS  = 50;
   localparam int LEAD = 25;
   localparam int LAT  = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr, upd, arm, pol;
   logic [2:0]  waddr;
   logic [31:0] wdata;
   logic        pulse, sstb, estb, done, trig, err;
   logic [11:0] sfine, efine;
   longint      lin;
   int          checks = 0;
   int          fails  = 0;

   always #2.5 clk = ~clk;

   // Time base: advances just after every rising edge.
   initial lin = 7 * CPS;
   always begin
      @(posedge clk);
      #1 lin = lin + 1;
   end

   abs_pulse_sched #(.CYC_PER_SEC(CPS), .MIN_LEAD(LEAD), .UPD_LAT(LAT)) i_abs_pulse_sched (
      .clk_i(clk), .rst_ni(rst_n),
      .tb_sec_i(32'(lin / CPS)), .tb_cyc_i(28'(lin % CPS)),
      .wr_i(wr), .wr_addr_i(waddr), .wr_data_i(wdata),
      .update_i(upd), .arm_i(arm), .pol_i(pol),
      .pulse_o(pulse), .start_stb_o(sstb), .end_stb_o(estb),
      .start_fine_o(sfine), .end_fine_o(efine),
      .done_o(done), .trig_o(trig), .err_o(err)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at lin=%0d", req, act, exp, lin);
      end
   endtask

   task automatic write_fld(input logic [2:0] a, input longint d);
      @(negedge clk);
      wr = 1'b1; waddr = a; wdata = 32'(d);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic do_update();
      @(negedge clk);
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      repeat (LAT) @(negedge clk);
   endtask

   task automatic program_times(input longint s, input longint e);
      write_fld(3'd0, s / CPS);
      write_fld(3'd1, s % CPS);
      write_fld(3'd2, 12'h3A5);
      write_fld(3'd3, e / CPS);
      write_fld(3'd4, e % CPS);
      write_fld(3'd5, 12'h5C3);
      do_update();
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr = 1'b0; upd = 1'b0; arm = 1'b0; pol = 1'b1;
      waddr = '0; wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pulse", pulse, 0);
      chk("R1 done", done, 1);
      chk("R1 trig", trig, 0);
      chk("R1 err", err, 0);
      chk("R1 sstb", sstb, 0);
      chk("R1 estb", estb, 0);
      chk("R1 sfine", sfine, 0);
      chk("R1 efine", efine, 0);

      // R2 truncation, R3 done window, R4 snapshot and busy update
      write_fld(3'd2, 'h123);
      write_fld(3'd5, 'hFFFFF);
      @(negedge clk);
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      for (int i = 0; i < LAT; i++) begin
         chk("R3 done low", done, 0);
         chk("R3 fine held", sfine, 0);
         if (i == 0) begin
            wr = 1'b1; waddr = 3'd2; wdata = 'h456; upd = 1'b1;
         end else begin
            wr = 1'b0; upd = 1'b0;
         end
         @(negedge clk);
      end
      wr = 1'b0; upd = 1'b0;
      chk("R3 done back", done, 1);
      chk("R4 snapshot start fine", sfine, 'h123);
      chk("R2 end fine truncated", efine, 'hFFF);
      @(negedge clk);
      chk("R4 busy update ignored", done, 1);
      write_fld(3'd6, 'hABC);
      write_fld(3'd7, 'hDEF);
      do_update();
      chk("R4 later update start fine", sfine, 'h456);
      chk("R2 unused codes end fine", efine, 'hFFF);

      // R5-R10 lead sweep across second boundaries
      for (int d = 0; d <= 40; d++) begin
         longint plan, s, e, lp;
         bit ok;
         @(negedge clk);
         plan = lin + 40;
         s = plan + d;
         e = s + 3 + (d % 4);
         ok = (d >= LEAD);
         program_times(s, e);
         chk("R2 start fine field", sfine, 'h3A5);
         chk("R2 end fine field", efine, 'h5C3);
         pol = d[0];
         while (lin != plan) @(negedge clk);
         arm = 1'b1;
         @(negedge clk);
         arm = 1'b0;
         chk("R5 lead decision (err)", err, !ok);
         chk("R9 arm clears trig", trig, 0);
         for (int k = 0; k < d + 12; k++) begin
            lp = lin - 1;
            chk("R7 R10 pulse level", pulse,
                (ok && lp >= s && lp < e) ? pol : !pol);
            chk("R8 start strobe", sstb, ok && lp == s);
            chk("R8 end strobe", estb, ok && lp == e);
            chk("R9 trig", trig, ok && lp >= e);
            chk("R6 err held", err, !ok);
            @(negedge clk);
         end
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule